// File: doc/BRIEF.md
# Double-Banked Wavetable DDS Lane

This block is one output lane of a direct digital synthesizer. A shared rate strobe marks each sample instant. On every strobe that finds the lane running, a 32-bit phase register grows by a 32-bit increment and wraps freely. Eight bits taken from the new phase select one byte of a 256-entry sample table. That byte is registered onto an 8-bit code port that feeds a DAC. Two instances placed side by side give a two-output generator.

The lane stores two complete tables. Only the bank not in use can be written, so new waveform data can be loaded while the lane keeps playing from the other bank. When the new data is in place, a single commit pulse does several things in the same clock edge. It zeroes the phase, loads a new increment, makes the freshly loaded bank the one in use, and sets the run state to the value supplied with the commit. The listener never hears a half-written table or a phase that belongs to the old settings. The sample strobe normally runs at 40 kHz: an 80 MHz clock is prescaled to 1 MHz, and every 25th tick of that is used. The strobe is produced outside this block.

Top module: `dds_lane`

## Requirements
- R1: After reset, `dacCode` is 0, `activeBank` is 0 (bank A), `wrErr` is 0, and the lane is stopped, so sample strobes leave `dacCode` at 0.
- R2: On a sample strobe while running, the phase becomes (phase + step) mod 2^32, where step is the last committed increment.
- R3: The table index is bits [23:16] of the updated phase. `dacCode` shows the active-bank entry at that index from the clock edge that follows the strobe, and holds it until the next accumulating strobe.
- R4: While stopped, a sample strobe changes neither the phase nor `dacCode`.
- R5: A write with `wrEn` high and `wrBank` different from `activeBank` stores `wrData` at `wrAddr` in the bank named by `wrBank` (0 = bank A, 1 = bank B).
- R6: A write with `wrBank` equal to `activeBank` leaves both banks unchanged. It raises `wrErr` for exactly the next cycle. `wrErr` is 0 in every other cycle.
- R7: A commit zeroes the phase, loads `commitStep`, toggles `activeBank` and sets the run state to `commitEnable`, all in one clock edge. `dacCode` does not change in that edge.
- R8: If a commit and a sample strobe occur in the same cycle, the commit wins and no accumulation takes place. The first later strobe yields phase = `commitStep`.
- R9: Writing the inactive bank while the lane is running does not disturb the samples read from the active bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleTick | input | 1 | One-cycle sample strobe shared by all lanes |
| wrEn | input | 1 | Table write request |
| wrBank | input | 1 | Bank addressed by the write (0 = A, 1 = B) |
| wrAddr | input | 8 | Table entry to write |
| wrData | input | 8 | Sample value to write |
| commitReq | input | 1 | One-cycle atomic commit request |
| commitStep | input | 32 | Phase increment loaded at commit |
| commitEnable | input | 1 | Run state applied at commit |
| dacCode | output | 8 | Registered DAC code |
| activeBank | output | 1 | Bank currently read by the lane |
| wrErr | output | 1 | One-cycle flag for a rejected write to the active bank |

## Verification
The phase register cannot be seen at the ports. A wrong increment, a missed clear or a wrong bit slice therefore shows up only as a wrong `dacCode` value. Because the bench tables hold distinct, position-dependent values, this error appears on the first accumulating strobe after the fault. A bank pointer that fails to swap, or a write that lands in the active bank, changes the code read at the very next strobe that addresses the affected entry. A write placed in the wrong bank shows up one commit later, when that bank is played. A missing or extra `wrErr` pulse is visible in the cycle right after the write.

// File: rtl/dds_lane_pkg.sv
package dds_lane_pkg;

  // strobes from the lane control to the datapath
  typedef struct packed {
    logic advance;    // accumulate phase and refresh the DAC code
    logic reload;     // clear phase and load a new increment
    logic memWe;      // write into the bank named by writeBank
    logic writeBank;  // target bank of the write
    logic readBank;   // bank the samples are read from
  } laneStrobe_t;

endpackage

// File: rtl/dds_lane_ctrl.sv
module dds_lane_ctrl
  import dds_lane_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleTick,
  input  logic        wrEn,
  input  logic        wrBank,
  input  logic        commitReq,
  input  logic        commitEnable,
  output laneStrobe_t strobes,
  output logic        activeBank,
  output logic        wrErr
);

  logic runReg;
  logic bankReg;
  logic errReg;
  logic hitActive;

  assign hitActive = wrEn && (wrBank == bankReg);

  // commit takes priority over the sample strobe
  always_comb begin
    strobes.advance   = sampleTick && runReg && !commitReq;
    strobes.reload    = commitReq;
    strobes.memWe     = wrEn && (wrBank != bankReg);
    strobes.writeBank = wrBank;
    strobes.readBank  = bankReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runReg  <= 1'b0;
      bankReg <= 1'b0;
      errReg  <= 1'b0;
    end else begin
      errReg <= hitActive;
      if (commitReq) begin
        runReg  <= commitEnable;
        bankReg <= ~bankReg;
      end
    end
  end

  assign activeBank = bankReg;
  assign wrErr      = errReg;

endmodule

// File: rtl/dds_lane_dp.sv
module dds_lane_dp
  import dds_lane_pkg::*;
#(
  parameter int PHASE_W = 32,
  parameter int IDX_W   = 8,
  parameter int IDX_LSB = 16,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  laneStrobe_t        strobes,
  input  logic [IDX_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [PHASE_W-1:0] commitStep,
  output logic [DATA_W-1:0]  dacCode
);

  localparam int DEPTH     = 1 << IDX_W;
  localparam int NUM_BANKS = 2;

  logic [PHASE_W-1:0] phase;
  logic [PHASE_W-1:0] step;
  logic [PHASE_W-1:0] phaseNext;
  logic [IDX_W-1:0]   tableIdx;
  logic [DATA_W-1:0]  readWord [NUM_BANKS];

  assign phaseNext = phase + step;
  assign tableIdx  = phaseNext[IDX_LSB +: IDX_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= '0;
      step  <= '0;
    end else if (strobes.reload) begin
      phase <= '0;
      step  <= commitStep;
    end else if (strobes.advance) begin
      phase <= phaseNext;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] bankMem [DEPTH];

    always_ff @(posedge clk) begin
      if (strobes.memWe && (strobes.writeBank == 1'(b)))
        bankMem[wrAddr] <= wrData;
    end

    assign readWord[b] = bankMem[tableIdx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      dacCode <= '0;
    else if (strobes.advance)
      dacCode <= readWord[strobes.readBank];
  end

endmodule

// File: rtl/dds_lane.sv
module dds_lane
  import dds_lane_pkg::*;
#(
  parameter int PHASE_W = 32,
  parameter int IDX_W   = 8,
  parameter int IDX_LSB = 16,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleTick,
  input  logic               wrEn,
  input  logic               wrBank,
  input  logic [IDX_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               commitReq,
  input  logic [PHASE_W-1:0] commitStep,
  input  logic               commitEnable,
  output logic [DATA_W-1:0]  dacCode,
  output logic               activeBank,
  output logic               wrErr
);

  laneStrobe_t strobes;

  dds_lane_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .sampleTick   (sampleTick),
    .wrEn         (wrEn),
    .wrBank       (wrBank),
    .commitReq    (commitReq),
    .commitEnable (commitEnable),
    .strobes      (strobes),
    .activeBank   (activeBank),
    .wrErr        (wrErr)
  );

  dds_lane_dp #(
    .PHASE_W (PHASE_W),
    .IDX_W   (IDX_W),
    .IDX_LSB (IDX_LSB),
    .DATA_W  (DATA_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .commitStep (commitStep),
    .dacCode    (dacCode)
  );

endmodule

// File: rtl/dds_lane_chk.sv
module dds_lane_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              sampleTick,
  input logic              wrEn,
  input logic              wrBank,
  input logic              commitReq,
  input logic [DATA_W-1:0] dacCode,
  input logic              activeBank,
  input logic              wrErr
);

  // R7
  bank_swap_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitReq |=> (activeBank != $past(activeBank)));

  // R7
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !commitReq |=> $stable(activeBank));

  // R6
  wr_err_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (wrBank == activeBank)) |=> wrErr);

  // R6
  wr_err_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && (wrBank == activeBank)) |=> !wrErr);

  // R4
  dac_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sampleTick |=> $stable(dacCode));

  // R8
  dac_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitReq |=> $stable(dacCode));

endmodule

bind dds_lane dds_lane_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sampleTick (sampleTick),
  .wrEn       (wrEn),
  .wrBank     (wrBank),
  .commitReq  (commitReq),
  .dacCode    (dacCode),
  .activeBank (activeBank),
  .wrErr      (wrErr)
);

// File: tb/dds_lane_tb.sv
module dds_lane_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleTick = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrBank = 1'b0;
  logic [7:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        commitReq = 1'b0;
  logic [31:0] commitStep = '0;
  logic        commitEnable = 1'b0;
  logic [7:0]  dacCode;
  logic        activeBank;
  logic        wrErr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  int          mTable [2][256];
  logic [31:0] mPhase = '0;
  logic [31:0] mStep = '0;
  bit          mRun = 1'b0;
  bit          mBank = 1'b0;
  int          mDac = 0;
  bit          mErr = 1'b0;

  always #5 clk = ~clk;

  dds_lane u_dut (
    .clk (clk), .rstN (rstN), .sampleTick (sampleTick),
    .wrEn (wrEn), .wrBank (wrBank), .wrAddr (wrAddr), .wrData (wrData),
    .commitReq (commitReq), .commitStep (commitStep), .commitEnable (commitEnable),
    .dacCode (dacCode), .activeBank (activeBank), .wrErr (wrErr)
  );

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic modelEdge();
    mErr = wrEn && (wrBank == mBank);
    if (wrEn && (wrBank != mBank)) mTable[wrBank][wrAddr] = int'(wrData);
    if (commitReq) begin
      mPhase = '0;
      mStep  = commitStep;
      mBank  = ~mBank;
      mRun   = commitEnable;
    end else if (sampleTick && mRun) begin
      mPhase = mPhase + mStep;
      mDac   = mTable[mBank][mPhase[23:16]];
    end
  endtask

  // one clock, model updated, outputs compared away from the edge
  task automatic cycle(string tag);
    @(posedge clk);
    if (rstN) modelEdge();
    @(negedge clk);
    check(tag, int'(dacCode), mDac, "dacCode");
    check(tag, int'(activeBank), int'(mBank), "activeBank");
    check(tag, int'(wrErr), int'(mErr), "wrErr");
    sampleTick = 1'b0; wrEn = 1'b0; commitReq = 1'b0;
  endtask

  task automatic fillBank(bit b, int seed, bit ticking, string tag);
    for (int i = 0; i < 256; i++) begin
      wrEn = 1'b1; wrBank = b; wrAddr = 8'(i);
      wrData = 8'((i * seed + 17 * b + 3) & 255);
      sampleTick = ticking && (i % 3 == 0);
      cycle(tag);
    end
  endtask

  task automatic commit(logic [31:0] st, bit en, bit withTick, string tag);
    commitReq = 1'b1; commitStep = st; commitEnable = en;
    sampleTick = withTick;
    cycle(tag);
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) begin
      sampleTick = (i % 3 == 0);
      cycle(tag);
    end
  endtask

  initial begin
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 256; i++) mTable[b][i] = 0;
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1", int'(dacCode), 0, "dacCode");
    check("R1", int'(activeBank), 0, "activeBank");
    check("R1", int'(wrErr), 0, "wrErr");
    rstN = 1'b1;
    @(negedge clk);
    run(12, "R1");

    // R6: write aimed at bank A while it is active
    wrEn = 1'b1; wrBank = 1'b0; wrAddr = 8'd5; wrData = 8'd99;
    cycle("R6");
    cycle("R6");

    // R5: load bank B, then commit with a simultaneous strobe (R8)
    fillBank(1'b1, 7, 1'b0, "R5");
    commit(32'h0003_8000, 1'b1, 1'b1, "R8");
    sampleTick = 1'b1;
    cycle("R8");
    run(150, "R3");

    // R9: rewrite bank A in the background while bank B plays
    fillBank(1'b0, 13, 1'b1, "R9");

    // R2: large step, wrapping phase, on bank A
    commit(32'hF123_4567, 1'b1, 1'b0, "R7");
    run(200, "R2");

    // R4: stopped lane ignores strobes
    commit(32'h0010_0000, 1'b0, 1'b0, "R7");
    run(30, "R4");

    // R6: step zero reads entry 0; a rejected write to it must not show
    commit(32'h0000_0000, 1'b1, 1'b0, "R7");
    sampleTick = 1'b1;
    cycle("R6");
    wrEn = 1'b1; wrBank = activeBank; wrAddr = 8'd0; wrData = 8'hA5;
    cycle("R6");
    sampleTick = 1'b1;
    cycle("R6");
    check("R6", int'(dacCode), mTable[mBank][0], "entry0 after rejected write");

    // R8: commit with strobe again, then the first strobe yields phase = step
    commit(32'h0001_0000, 1'b1, 1'b1, "R8");
    sampleTick = 1'b1;
    cycle("R8");
    check("R8", int'(dacCode), mTable[mBank][1], "first sample index");
    run(20, "R2");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule